// File: doc/BRIEF.md
# Twin-Predicated Element Index Sequencer

This block steps through the elements of one vector operation when the source side and the destination side each carry their own predicate mask. After a start strobe it puts out, at most one per clock, a pair of element offsets: one for the source and one for the destination. A later stage adds each offset to its base register number. The two sides walk independently. Each one jumps straight to its next set mask bit below the vector length. A side marked scalar stays on offset zero and never moves.

Broadcasting a scalar to a vector, inserting into a vector at a masked position, and extracting one vector element at a masked position all come from this one walk. They differ only in how the masks and the scalar flags are set. The sequencer does no register reads, no hazard handling and no data movement. It only produces the index stream and a done pulse.

Top module: `twin_pred_seq`

## Requirements
- R1: The source and destination each keep their own step. A vector side always presents the lowest set bit of its own mask at or above its step and below the vector length. After each emitted pair, that side's step becomes the emitted position plus one.
- R2: A side whose scalar flag is 1 presents offset 0 on every pair and never advances.
- R3: With a scalar source whose mask has any set bit below the length, and a vector destination with all mask bits set, one pair is emitted per element 0..VL-1. The source offset is always 0 and the destination offsets are 0,1,2,...
- R4: With a scalar source and a vector destination whose mask has a single set bit at k < VL, exactly one pair (src 0, dst k) is emitted.
- R5: With a vector source whose mask has a single set bit at k < VL, and either a scalar destination or an all-ones destination mask, the first pair emitted is (src k, dst 0).
- R6: When the destination is scalar, the sequence ends after its first pair. `doneO` is raised in the same cycle as that pair's `validO`.
- R7: When either side finds no set bit in [step, VL), no pair is emitted. `doneO` pulses for one cycle, one cycle after the last pair, and the sequencer returns to idle. Mask bits at or above VL are never used.
- R8: A vector length of 0 gives no valid output, and `doneO` pulses in the cycle after the start was sampled.
- R9: A start strobe that arrives while a sequence is in progress is ignored. The running sequence continues unchanged.
- R10: The first pair appears one cycle after the start is sampled. Pairs follow at one per cycle with outputs registered, and `validO` is high only in cycles that carry a pair.
- R11: After reset, `validO` and `doneO` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Starts a sequence when idle |
| vlenI | input | 7 | Vector length, 0 to 64 |
| srcMaskI | input | 64 | Source predicate mask |
| dstMaskI | input | 64 | Destination predicate mask |
| srcScalarI | input | 1 | 1: source side is scalar |
| dstScalarI | input | 1 | 1: destination side is scalar |
| validO | output | 1 | A pair is presented this cycle |
| srcIdxO | output | 6 | Source element offset |
| dstIdxO | output | 6 | Destination element offset |
| doneO | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The hardest case to reach is a start strobe that lands in the middle of a long run. The stimulus sets up a walk with many set bits and pulses start again, with quite different masks and flags, a few cycles in. It then checks that the offsets still follow the first set of operands up to the done pulse. Sparse masks that have set bits above the vector length are also driven. These show that the skip search stops at the length rather than at the end of the mask.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef struct packed {
    logic load;    // capture operands, clear steps
    logic emit;    // a pair is produced this cycle
    logic finish;  // sequence ends this cycle
  } tps_ctrl_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_WALK = 1'b1} tps_state_e;
endpackage

// File: rtl/tps_side.sv
module tps_side #(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL),
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadI,
  input  logic              emitI,
  input  logic [MAX_VL-1:0] maskI,
  input  logic              scalarI,
  input  logic [VL_W-1:0]   vlenQ,
  output logic              foundO,
  output logic [IDX_W-1:0]  offsetO,
  output logic              scalarQ
);
  logic [MAX_VL-1:0] maskQ;
  logic [VL_W-1:0]   stepQ;
  logic [VL_W-1:0]   fromPos;
  logic [IDX_W-1:0]  hitPos;
  logic              hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      scalarQ <= 1'b0;
      stepQ   <= '0;
    end else if (loadI) begin
      maskQ   <= maskI;
      scalarQ <= scalarI;
      stepQ   <= '0;
    end else if (emitI && !scalarQ) begin
      stepQ   <= VL_W'(hitPos) + VL_W'(1);
    end
  end

  // lowest set bit in [fromPos, vlenQ): scan downward so the lowest wins
  always_comb begin
    fromPos = scalarQ ? '0 : stepQ;
    hit     = 1'b0;
    hitPos  = '0;
    for (int i = MAX_VL - 1; i >= 0; i--) begin
      if (maskQ[i] && (VL_W'(i) >= fromPos) && (VL_W'(i) < vlenQ)) begin
        hit    = 1'b1;
        hitPos = IDX_W'(i);
      end
    end
  end

  assign foundO  = hit;
  assign offsetO = scalarQ ? '0 : hitPos;
endmodule

// File: rtl/tps_control.sv
module tps_control
  import tps_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startI,
  input  logic      srcFound,
  input  logic      dstFound,
  input  logic      dstScalar,
  output tps_ctrl_t ctrl,
  output logic      busy
);
  tps_state_e state, stateNext;
  logic       pairOk;

  assign pairOk = srcFound && dstFound;

  always_comb begin
    stateNext   = state;
    ctrl        = '0;
    unique case (state)
      ST_IDLE: begin
        ctrl.load = startI;
        if (startI) stateNext = ST_WALK;
      end
      ST_WALK: begin
        ctrl.emit   = pairOk;
        ctrl.finish = !pairOk || dstScalar;
        if (ctrl.finish) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == ST_WALK);
endmodule

// File: rtl/tps_datapath.sv
module tps_datapath
  import tps_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL),
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tps_ctrl_t         ctrl,
  input  logic [VL_W-1:0]   vlenI,
  input  logic [MAX_VL-1:0] srcMaskI,
  input  logic [MAX_VL-1:0] dstMaskI,
  input  logic              srcScalarI,
  input  logic              dstScalarI,
  output logic              srcFound,
  output logic              dstFound,
  output logic              srcScalarQ,
  output logic              dstScalarQ,
  output logic              validO,
  output logic [IDX_W-1:0]  srcIdxO,
  output logic [IDX_W-1:0]  dstIdxO,
  output logic              doneO
);
  logic [VL_W-1:0]  vlenQ;
  logic [IDX_W-1:0] srcOff, dstOff;

  always_ff @(posedge clk) begin
    if (!rstN)          vlenQ <= '0;
    else if (ctrl.load) vlenQ <= vlenI;
  end

  tps_side #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_src (
    .clk(clk), .rstN(rstN), .loadI(ctrl.load), .emitI(ctrl.emit),
    .maskI(srcMaskI), .scalarI(srcScalarI), .vlenQ(vlenQ),
    .foundO(srcFound), .offsetO(srcOff), .scalarQ(srcScalarQ));

  tps_side #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_dst (
    .clk(clk), .rstN(rstN), .loadI(ctrl.load), .emitI(ctrl.emit),
    .maskI(dstMaskI), .scalarI(dstScalarI), .vlenQ(vlenQ),
    .foundO(dstFound), .offsetO(dstOff), .scalarQ(dstScalarQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validO  <= 1'b0;
      doneO   <= 1'b0;
      srcIdxO <= '0;
      dstIdxO <= '0;
    end else begin
      validO <= ctrl.emit;
      doneO  <= ctrl.finish;
      if (ctrl.emit) begin
        srcIdxO <= srcOff;
        dstIdxO <= dstOff;
      end
    end
  end
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import tps_pkg::*;
#(
  parameter int MAX_VL = 64,
  parameter int IDX_W  = $clog2(MAX_VL),
  parameter int VL_W   = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startI,
  input  logic [VL_W-1:0]   vlenI,
  input  logic [MAX_VL-1:0] srcMaskI,
  input  logic [MAX_VL-1:0] dstMaskI,
  input  logic              srcScalarI,
  input  logic              dstScalarI,
  output logic              validO,
  output logic [IDX_W-1:0]  srcIdxO,
  output logic [IDX_W-1:0]  dstIdxO,
  output logic              doneO
);
  tps_ctrl_t ctrl;
  logic      busy, srcFound, dstFound, srcScalarQ, dstScalarQ;

  tps_control u_ctl (
    .clk(clk), .rstN(rstN), .startI(startI),
    .srcFound(srcFound), .dstFound(dstFound), .dstScalar(dstScalarQ),
    .ctrl(ctrl), .busy(busy));

  tps_datapath #(.MAX_VL(MAX_VL), .IDX_W(IDX_W), .VL_W(VL_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .vlenI(vlenI),
    .srcMaskI(srcMaskI), .dstMaskI(dstMaskI),
    .srcScalarI(srcScalarI), .dstScalarI(dstScalarI),
    .srcFound(srcFound), .dstFound(dstFound),
    .srcScalarQ(srcScalarQ), .dstScalarQ(dstScalarQ),
    .validO(validO), .srcIdxO(srcIdxO), .dstIdxO(dstIdxO), .doneO(doneO));
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             startI,
  input logic             busy,
  input logic             srcScalarQ,
  input logic             dstScalarQ,
  input logic             validO,
  input logic             doneO,
  input logic [IDX_W-1:0] srcIdxO,
  input logic [IDX_W-1:0] dstIdxO
);
  a_r2_src_scalar_zero: assert property (@(posedge clk) disable iff (!rstN)
    (validO && srcScalarQ) |-> (srcIdxO == '0));

  a_r2_dst_scalar_zero: assert property (@(posedge clk) disable iff (!rstN)
    (validO && dstScalarQ) |-> (dstIdxO == '0));

  a_r6_dst_scalar_single: assert property (@(posedge clk) disable iff (!rstN)
    (validO && dstScalarQ) |-> doneO);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startI) |=> ($stable(srcScalarQ) && $stable(dstScalarQ)));

  a_r1_src_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (validO && $past(validO) && !$past(doneO) && !srcScalarQ) |-> (srcIdxO > $past(srcIdxO)));

  a_r1_dst_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (validO && $past(validO) && !$past(doneO) && !dstScalarQ) |-> (dstIdxO > $past(dstIdxO)));

  a_r7_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !validO);
endmodule

bind twin_pred_seq tps_checker #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/twin_pred_seq_bench.sv
module twin_pred_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [6:0]  vlenI = '0;
  logic [63:0] srcMaskI = '0, dstMaskI = '0;
  logic        srcScalarI = 1'b0, dstScalarI = 1'b0;
  logic        validO, doneO;
  logic [5:0]  srcIdxO, dstIdxO;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_pred_seq u_twin_pred_seq (
    .clk(clk), .rstN(rstN), .startI(startI), .vlenI(vlenI),
    .srcMaskI(srcMaskI), .dstMaskI(dstMaskI),
    .srcScalarI(srcScalarI), .dstScalarI(dstScalarI),
    .validO(validO), .srcIdxO(srcIdxO), .dstIdxO(dstIdxO), .doneO(doneO));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: list of pairs for one sequence
  task automatic model(input int vl, input logic [63:0] sm, input logic [63:0] dm,
                       input bit ss, input bit ds, ref int qs[$], ref int qd[$]);
    int sp = 0, dp = 0;
    qs.delete(); qd.delete();
    forever begin
      int s = -1, d = -1;
      for (int i = vl - 1; i >= 0; i--) begin
        if (i < 64 && sm[i] && (ss || i >= sp)) s = i;
        if (i < 64 && dm[i] && (ds || i >= dp)) d = i;
      end
      if (s < 0 || d < 0) break;
      qs.push_back(ss ? 0 : s);
      qd.push_back(ds ? 0 : d);
      if (ds) break;
      if (!ss) sp = s + 1;
      dp = d + 1;
    end
  endtask

  // run one sequence and compare every cycle; optional restart at cycle 2
  task automatic runSeq(input string req, input int vl, input logic [63:0] sm,
                        input logic [63:0] dm, input bit ss, input bit ds,
                        input bit poke);
    int qs[$], qd[$];
    int n, doneCyc;
    model(vl, sm, dm, ss, ds, qs, qd);
    n = qs.size();
    doneCyc = (ds && n == 1) ? 1 : n + 1;
    @(negedge clk);
    vlenI = 7'(vl); srcMaskI = sm; dstMaskI = dm;
    srcScalarI = ss; dstScalarI = ds; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    check({req, " R10 no early valid"}, validO, 0);
    for (int k = 1; k <= doneCyc + 1; k++) begin
      if (poke && k == 2) begin
        startI = 1'b1; vlenI = 7'd3; srcMaskI = '1; dstMaskI = '1;
        srcScalarI = 1'b1; dstScalarI = 1'b1;
      end
      @(negedge clk);
      startI = 1'b0;
      if (k <= n) begin
        check({req, " R10 valid"}, validO, 1);
        check({req, " R1 src offset"}, srcIdxO, qs[k-1]);
        check({req, " R1 dst offset"}, dstIdxO, qd[k-1]);
      end else begin
        check({req, " R7 no valid"}, validO, 0);
      end
      check({req, " R7 done timing"}, doneO, (k == doneCyc) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", validO, 0);
    check("R11 reset done", doneO, 0);
    rstN = 1'b1;
    runSeq("R3 splat", 8, 64'h1, '1, 1, 0, 0);
    runSeq("R4 insert", 16, '1, 64'h1 << 5, 1, 0, 0);
    runSeq("R5 extract scalar dst", 16, 64'h1 << 3, '1, 0, 1, 0);
    runSeq("R5 extract vector dst", 16, 64'h1 << 9, '1, 0, 0, 0);
    runSeq("R8 zero length", 0, '1, '1, 0, 0, 0);
    runSeq("R1 full length", 64, '1, '1, 0, 0, 0);
    runSeq("R1 sparse", 40, 64'hF0F0_0000_A5A5_1234, 64'h0000_00FF_0101_8001, 0, 0, 0);
    runSeq("R7 mask above length", 10, 64'hFFFF_0000_0000_0204, '1, 0, 0, 0);
    runSeq("R6 scalar both", 12, 64'h10, 64'h20, 1, 1, 0);
    runSeq("R7 empty src scalar dst", 12, 64'h0, '1, 0, 1, 0);
    runSeq("R2 scalar src sparse dst", 30, 64'h8, 64'h2400_0091, 1, 0, 0);
    runSeq("R9 restart ignored", 32, 64'hAAAA_AAAA, 64'h5555_5555, 0, 0, 1);
    for (int r = 0; r < 20; r++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom} | {$urandom, $urandom};
      runSeq("R1 random", int'($urandom_range(0, 64)), a, b, r[0], r[1] & r[2], r[3]);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule